// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter (Slave Timing)

This block takes one stereo sample pair at a time over a valid/ready handshake and shifts both words out on a single serial data line. It does not generate any clocks. It follows a bit clock and a channel-select (word) clock supplied by an external master, sampling both in the system clock domain. The data line is updated right after each bit-clock falling edge, so a receiver can capture it on the next rising edge.

Two frame formats are supported. In I2S alignment the word starts one bit clock after the channel clock changes. In right-justified alignment the word ends on the last bit slot before the change. The channel polarity also differs between them. Word length is 16, 20 or 24 bits, taken from the low bits of each sample input. For right-justified timing the block measures the length of each half-frame and uses it to place the next word.

One pair is held in a single-entry buffer and moved into the shifting pair at every frame start, which is the change into the left channel. If the buffer is empty at a frame start, the previous pair is sent again and an underrun flag is raised. The controller has four states:

- `ST_IDLE`: reset.
- `ST_SYNC`: the channel clock has been captured once and the block waits for its first change.
- `ST_LEFT`: the left word is being sent.
- `ST_RIGHT`: the right word is being sent.

The transitions are:

- IDLE to SYNC on the first bit-clock rise.
- SYNC to LEFT or RIGHT on the first channel-clock change, picked by the new channel.
- LEFT and RIGHT to the decoded channel on every later change.

Top module: `audtx_serializer`

## Requirements
- R1: While reset is asserted, `sdata_o` is 0, `underrun_o` is 0 and `smp_ready_o` is 1.
- R2: `sdata_o` changes only in the clock cycle after a bit-clock falling edge has been detected. The channel clock is sampled on bit-clock rising edges, and a change seen there starts a new half-frame at bit position 0.
- R3: With `fmt_i`=1 (I2S), channel clock low selects left and high selects right. The MSB is driven at the first falling edge after the one at which the channel clock changed, and the remaining bits follow MSB first. Slots past the word carry 0.
- R4: With `fmt_i`=0 (right-justified), channel clock high selects left and low selects right. The LSB is driven at the last falling edge before the one at which the channel clock changes. Bits go out MSB first, and earlier slots carry 0. If the half-frame is shorter than the word, the upper bits are dropped.
- R5: In right-justified mode the word is placed using the number of bit-clock falls counted in the previous half-frame. The first half-frame after synchronising has no such count and carries all zeros.
- R6: `wlen_i` selects the word length: 0 gives 16 bits, 1 gives 20, and 2 or 3 give 24. The word sent is the low bits of the sample input.
- R7: `smp_ready_o` is high exactly when the buffer is empty. `smp_valid_i` with ready high stores the pair. `smp_valid_i` with ready low is ignored.
- R8: At each frame start (a change into the left channel), a full buffer moves to the shifting pair, ready returns high and `underrun_o` clears.
- R9: At a frame start with an empty buffer, the previous pair is sent again and `underrun_o` goes high until a later frame start finds a stored pair.
- R10: Before the first channel-clock change after reset, `sdata_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | External bit clock, sampled by `clk` |
| lrck_i | input | 1 | External channel (word) clock, sampled by `clk` |
| fmt_i | input | 1 | 0 right-justified, 1 I2S |
| wlen_i | input | 2 | Word length select (0:16, 1:20, 2/3:24) |
| smp_valid_i | input | 1 | Sample pair offered |
| smp_ready_o | output | 1 | Buffer empty, pair can be taken |
| smp_left_i | input | SMP_W | Left sample |
| smp_right_i | input | SMP_W | Right sample |
| sdata_o | output | 1 | Serial data out |
| underrun_o | output | 1 | Last frame start found no new pair |

## Verification
The embedded properties check the following on every cycle:

- The data line moves only after a detected bit-clock fall.
- The line stays silent before synchronisation.
- An accepted pair drops ready.
- A frame start either releases the buffer or raises the underrun flag.

Bit placement can only be shown by the bench's scenarios, which decode each half-frame and compare it with a model of the alignment rules. These scenarios cover both formats, all word lengths and half-frames that are shorter or longer than the word. They also cover a right-justified half-frame following a half of a different length, a repeated pair after a skipped load, and a second offer ignored while the buffer is full.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

    typedef enum logic {
        FMT_RJ  = 1'b0,
        FMT_I2S = 1'b1
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_LEFT  = 2'd2,
        ST_RIGHT = 2'd3
    } tx_state_e;

    // Word length in bits for a select code.
    function automatic logic [4:0] wlen_bits(input logic [1:0] sel);
        logic [4:0] r;
        unique case (sel)
            2'd0:    r = 5'd16;
            2'd1:    r = 5'd20;
            default: r = 5'd24;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/audtx_clk_edge.sv
module audtx_clk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lrck_i,
    output logic rise_o,
    output logic fall_o,
    output logic first_o,
    output logic trans_o,
    output logic lvl_o
);
    logic bclk_q;
    logic lrck_cap;
    logic cap_vld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q   <= 1'b0;
            lrck_cap <= 1'b0;
            cap_vld  <= 1'b0;
        end else begin
            bclk_q <= bclk_i;
            if (rise_o) begin
                lrck_cap <= lrck_i;
                cap_vld  <= 1'b1;
            end
        end
    end

    always_comb begin
        rise_o  = bclk_i & ~bclk_q;
        fall_o  = ~bclk_i & bclk_q;
        first_o = rise_o & ~cap_vld;
        trans_o = rise_o & cap_vld & (lrck_i != lrck_cap);
        lvl_o   = lrck_i;
    end

endmodule

// File: rtl/audtx_frame_fsm.sv
module audtx_frame_fsm
    import audtx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic             first_i,
    input  logic             trans_i,
    input  logic             lvl_i,
    input  fmt_e             fmt_i,
    output logic             run_o,
    output logic             is_left_o,
    output logic             frame_start_o,
    output logic [CNT_W-1:0] pos_o,
    output logic [CNT_W-1:0] hf_len_o,
    output logic             hf_ok_o
);
    localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

    tx_state_e state_q, state_d;
    logic      left_now;

    // Next-state and output decode
    always_comb begin
        left_now      = (fmt_i == FMT_RJ) ? lvl_i : ~lvl_i;
        state_d       = state_q;
        unique case (state_q)
            ST_IDLE:  if (first_i) state_d = ST_SYNC;
            ST_SYNC:  if (trans_i) state_d = left_now ? ST_LEFT : ST_RIGHT;
            ST_LEFT:  if (trans_i) state_d = left_now ? ST_LEFT : ST_RIGHT;
            ST_RIGHT: if (trans_i) state_d = left_now ? ST_LEFT : ST_RIGHT;
            default:  state_d = ST_IDLE;
        endcase
        run_o         = (state_q == ST_LEFT) || (state_q == ST_RIGHT);
        is_left_o     = (state_q == ST_LEFT);
        frame_start_o = trans_i & left_now;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Position counter and half-frame length measurement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_o    <= '0;
            hf_len_o <= '0;
            hf_ok_o  <= 1'b0;
        end else begin
            if (trans_i) begin
                pos_o <= '0;
                if (run_o) begin
                    hf_len_o <= pos_o;
                    hf_ok_o  <= 1'b1;
                end
            end else if (fall_i && pos_o != POS_MAX) begin
                pos_o <= pos_o + 1'b1;
            end
        end
    end

    // R10: leaving reset never skips the sync state
    p_idle_to_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q != ST_LEFT && state_q != ST_RIGHT));

endmodule

// File: rtl/audtx_pair_buf.sv
module audtx_pair_buf #(
    parameter int SMP_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [SMP_W-1:0] left_i,
    input  logic [SMP_W-1:0] right_i,
    input  logic             frame_start_i,
    output logic             ready_o,
    output logic [SMP_W-1:0] act_l_o,
    output logic [SMP_W-1:0] act_r_o,
    output logic             underrun_o
);
    logic             full_q;
    logic [SMP_W-1:0] buf_l, buf_r;

    assign ready_o = ~full_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q     <= 1'b0;
            buf_l      <= '0;
            buf_r      <= '0;
            act_l_o    <= '0;
            act_r_o    <= '0;
            underrun_o <= 1'b0;
        end else begin
            if (frame_start_i) begin
                if (full_q) begin
                    act_l_o    <= buf_l;
                    act_r_o    <= buf_r;
                    underrun_o <= 1'b0;
                end else begin
                    underrun_o <= 1'b1;
                end
            end
            if (valid_i && !full_q) begin
                full_q <= 1'b1;
                buf_l  <= left_i;
                buf_r  <= right_i;
            end else if (frame_start_i && full_q) begin
                full_q <= 1'b0;
            end
        end
    end

    p_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o) |=> !ready_o);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && !ready_o) |=> (ready_o && !underrun_o));

    p_underrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && ready_o) |=> underrun_o);

endmodule

// File: rtl/audtx_bit_sel.sv
module audtx_bit_sel
    import audtx_pkg::*;
#(
    parameter int SMP_W = 24,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic             run_i,
    input  logic             is_left_i,
    input  fmt_e             fmt_i,
    input  logic [1:0]       wlen_i,
    input  logic [CNT_W-1:0] pos_i,
    input  logic [CNT_W-1:0] hf_len_i,
    input  logic             hf_ok_i,
    input  logic [SMP_W-1:0] act_l_i,
    input  logic [SMP_W-1:0] act_r_i,
    output logic             sdata_o
);
    localparam int IW = CNT_W + 2;
    localparam int SW = $clog2(SMP_W);
    localparam logic signed [IW-1:0] ONE = 1;
    localparam logic signed [IW-1:0] TWO = 2;

    logic signed [IW-1:0] w_s, pos_s, len_s, idx;
    logic [SMP_W-1:0]     word;
    logic                 in_word;
    logic                 nxt_bit;

    always_comb begin
        w_s     = $signed({{(IW-5){1'b0}}, wlen_bits(wlen_i)});
        pos_s   = $signed({2'b00, pos_i});
        len_s   = $signed({2'b00, hf_len_i});
        idx     = (fmt_i == FMT_I2S) ? (w_s - ONE - pos_s) : (len_s - TWO - pos_s);
        in_word = !idx[IW-1] && (idx < w_s) && ((fmt_i == FMT_I2S) || hf_ok_i);
        word    = is_left_i ? act_l_i : act_r_i;
        nxt_bit = run_i && in_word && word[idx[SW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      sdata_o <= 1'b0;
        else if (fall_i) sdata_o <= nxt_bit;
    end

    p_change_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_o) |-> $past(fall_i));

    p_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && !run_i) |=> !sdata_o);

endmodule

// File: rtl/audtx_serializer.sv
module audtx_serializer
    import audtx_pkg::*;
#(
    parameter int SMP_W = 24,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             lrck_i,
    input  logic             fmt_i,
    input  logic [1:0]       wlen_i,
    input  logic             smp_valid_i,
    output logic             smp_ready_o,
    input  logic [SMP_W-1:0] smp_left_i,
    input  logic [SMP_W-1:0] smp_right_i,
    output logic             sdata_o,
    output logic             underrun_o
);
    logic             rise, fall, first, trans, lvl;
    logic             run, is_left, frame_start, hf_ok;
    logic [CNT_W-1:0] pos, hf_len;
    logic [SMP_W-1:0] act_l, act_r;
    fmt_e             fmt;

    assign fmt = fmt_e'(fmt_i);

    audtx_clk_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_i  (bclk_i),
        .lrck_i  (lrck_i),
        .rise_o  (rise),
        .fall_o  (fall),
        .first_o (first),
        .trans_o (trans),
        .lvl_o   (lvl)
    );

    audtx_frame_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .fall_i        (fall),
        .first_i       (first),
        .trans_i       (trans),
        .lvl_i         (lvl),
        .fmt_i         (fmt),
        .run_o         (run),
        .is_left_o     (is_left),
        .frame_start_o (frame_start),
        .pos_o         (pos),
        .hf_len_o      (hf_len),
        .hf_ok_o       (hf_ok)
    );

    audtx_pair_buf #(.SMP_W(SMP_W)) u_buf (
        .clk           (clk),
        .rst_n         (rst_n),
        .valid_i       (smp_valid_i),
        .left_i        (smp_left_i),
        .right_i       (smp_right_i),
        .frame_start_i (frame_start),
        .ready_o       (smp_ready_o),
        .act_l_o       (act_l),
        .act_r_o       (act_r),
        .underrun_o    (underrun_o)
    );

    audtx_bit_sel #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (fall),
        .run_i     (run),
        .is_left_i (is_left),
        .fmt_i     (fmt),
        .wlen_i    (wlen_i),
        .pos_i     (pos),
        .hf_len_i  (hf_len),
        .hf_ok_i   (hf_ok),
        .act_l_i   (act_l),
        .act_r_i   (act_r),
        .sdata_o   (sdata_o)
    );

    // R2: the rise detector never fires together with the fall detector
    p_edge_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise, fall}));

endmodule

// File: tb/audtx_serializer_tb_top.sv
module audtx_serializer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b1, lrck = 1'b0, fmt = 1'b0, valid = 1'b0;
    logic [1:0]  wlen = 2'd0;
    logic [23:0] sl = '0, sr = '0;
    logic        ready, sdata, under;

    always #4 clk = ~clk;

    audtx_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrck_i(lrck), .fmt_i(fmt),
        .wlen_i(wlen), .smp_valid_i(valid), .smp_ready_o(ready),
        .smp_left_i(sl), .smp_right_i(sr), .sdata_o(sdata), .underrun_o(under)
    );

    int n_vec = 0, n_bad = 0;

    // bench model state
    bit          m_full, m_under, c_chk, last_ok, c_pok;
    logic [23:0] m_bl, m_br, m_al, m_ar, c_word;
    int          c_len, c_plen, last_len;
    logic [127:0] act_v;

    task automatic chk(input bit ok, input string req, input logic [127:0] a, input logic [127:0] e);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, a, e);
        end
    endtask

    function automatic logic exp_bit(input bit i2s, input int w, input int plen, input bit pok,
                                     input int p, input logic [23:0] word);
        int idx;
        if (i2s) idx = w - 1 - p;
        else begin
            if (!pok) return 1'b0;
            idx = plen - 2 - p;
        end
        return (idx >= 0 && idx < w) ? word[idx] : 1'b0;
    endfunction

    function automatic int wbits(input logic [1:0] s);
        return (s == 2'd0) ? 16 : (s == 2'd1) ? 20 : 24;
    endfunction

    task automatic tick(input logic lr, input bit psh, input logic [23:0] pl,
                        input logic [23:0] pr, output logic b);
        @(negedge clk);
        bclk = 1'b0;
        lrck = lr;
        if (psh) begin
            chk(ready == !m_full, "R7 ready on offer", {127'd0, ready}, {127'd0, !m_full});
            valid = 1'b1; sl = pl; sr = pr;
            if (!m_full) begin m_full = 1'b1; m_bl = pl; m_br = pr; end
        end
        @(negedge clk);
        valid = 1'b0;
        @(negedge clk);
        b = sdata;
        bclk = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_half(input logic b);
        logic [127:0] e;
        if (!c_chk) return;
        act_v[c_len-1] = b;
        e = '0;
        for (int p = 0; p < c_len; p++) e[p] = exp_bit(fmt, wbits(wlen), c_plen, c_pok, p, c_word);
        // R2/R3/R4/R5/R6: half-frame bit pattern
        chk(act_v == e, fmt ? "R3/R6 i2s half" : (c_pok ? "R4/R6 rj half" : "R5 rj first half"), act_v, e);
    endtask

    task automatic run_half(input bit left, input int n, input bit psh, input bit psh2, input bit last);
        logic b;
        logic lr;
        logic [23:0] al, ar, bl, br;
        lr = left ? ~fmt : fmt;
        al = 24'($urandom); ar = 24'($urandom); bl = 24'($urandom); br = 24'($urandom);
        tick(lr, 1'b0, '0, '0, b);
        finish_half(b);
        if (last) return;
        if (left) begin
            if (m_full) begin m_al = m_bl; m_ar = m_br; m_full = 1'b0; m_under = 1'b0; end
            else m_under = 1'b1;
        end
        c_word = left ? m_al : m_ar;
        c_len = n; c_plen = last_len; c_pok = last_ok; c_chk = 1'b1;
        last_len = n; last_ok = 1'b1;
        act_v = '0;
        for (int k = 1; k < n; k++) begin
            tick(lr, (k == 2 && psh) || (k == 3 && psh2), (k == 2) ? al : bl, (k == 2) ? ar : br, b);
            act_v[k-1] = b;
            if (k == 1 && left) begin
                chk(under == m_under, "R8/R9 underrun flag", {127'd0, under}, {127'd0, m_under});
                chk(ready == !m_full, "R8 ready after frame start", {127'd0, ready}, {127'd0, !m_full});
            end
        end
    endtask

    task automatic scen(input bit i2s, input logic [1:0] ws, input int nfr);
        logic b;
        int n;
        rst_n = 1'b0; fmt = i2s; wlen = ws; bclk = 1'b1; lrck = i2s; valid = 1'b0;
        m_full = 0; m_under = 0; m_al = '0; m_ar = '0; c_chk = 0; last_ok = 0; last_len = 0;
        repeat (3) @(negedge clk);
        chk(sdata == 1'b0 && under == 1'b0 && ready == 1'b1, "R1 reset state",
            {125'd0, sdata, under, ready}, 128'd1);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick(i2s, k == 1, 24'($urandom), 24'($urandom), b);
            chk(b == 1'b0, "R10 silent before sync", {127'd0, b}, 128'd0);
        end
        for (int f = 0; f < nfr; f++) begin
            n = (f == 2) ? 20 : 18 + int'($urandom % 17);
            run_half(1'b1, n, f != 3, f == 1, 1'b0);
            run_half(1'b0, n, 1'b0, 1'b0, 1'b0);
        end
        run_half(1'b1, 24, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++)
                scen(m[0], s[1:0], 6);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule